// File: doc/BRIEF.md
# Interrupt Status Enable Mask Unit

This block collects fifteen single-cycle event pulses from a network controller and drives one level-sensitive interrupt line. Each pulse sets a sticky bit in a status register. A bit stays set until software reads the status register, and that read clears it. The status bits record events whether or not the source is enabled. The interrupt line is high while any recorded event belongs to an enabled source.

Software controls the enables through two write-only registers. Writing ones to the set register enables those sources. Writing ones to the clear register disables them. Zero bits in either write leave their sources unchanged. A read-only view shows the enables in inverted form, so a 1 marks a source that cannot raise the line. All sources come out of reset disabled.

The register port is a simple synchronous bus. It has a write strobe and a read strobe, a two-bit register address, and 32-bit data. Read data is combinational and is valid in the cycle of the read strobe.

Top module: `irq_gather`

## Requirements
- R1: After reset the status register reads 0, the mask view (address 3) reads 0x00007FFF, and `irq_o` is low.
- R2: A 1 on any bit of `ev_i` at a clock edge sets the matching status bit, whether or not that source is enabled. The bit stays set until the status register (address 0) is read.
- R3: A read of address 0 returns the current status in bits 14:0 and clears every status bit at that clock edge. Bits 31:15 read 0.
- R4: An event that arrives in the same cycle as a status read is set in the status register after the read.
- R5: A write to address 1 enables each source whose data bit is 1. Data bits that are 0 leave their sources unchanged.
- R6: A write to address 2 disables each source whose data bit is 1. Data bits that are 0 leave their sources unchanged.
- R7: Reading address 3 returns a 1 in bit i when source i is disabled and a 0 when it is enabled. Bits 31:15 read 0.
- R8: `irq_o` is high exactly when some status bit is set and its source is enabled. The line updates in the cycle after the register change that causes it.
- R9: Reads of addresses 1 and 2 return 0. Writes to addresses 0 and 3 change neither the status nor the enables.
- R10: A read of address 3 does not clear the status register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ev_i | input | 15 | Event pulses, one per source |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register address: 0 status, 1 enable-set, 2 enable-clear, 3 mask view |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while `bus_rd` is high |
| irq_o | output | 1 | Combined interrupt line |

## Verification
If a status bit is lost or wrongly kept, it shows up on `irq_o` in the next cycle once that source is enabled, and it shows up in the value returned by the next status read. If an enable bit is corrupted, the next mask-view read shows it, and `irq_o` shows it as soon as that source has a pending event. The bench checks `irq_o` every cycle against a model of both registers. It also compares every read against that model, so a divergence shows up within one cycle of the first observation that depends on it.

// File: rtl/irq_gather.sv
module irq_gather #(
  parameter int NSRC = 15,
  parameter int DW   = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] ev_i,
  input  logic            bus_wr,
  input  logic            bus_rd,
  input  logic [1:0]      bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  output logic            irq_o
);
  localparam logic [1:0] A_STAT = 2'd0;
  localparam logic [1:0] A_SET  = 2'd1;
  localparam logic [1:0] A_CLR  = 2'd2;
  localparam logic [1:0] A_MASK = 2'd3;
  localparam int PAD = DW - NSRC;

  logic [NSRC-1:0] status_q, en_q;
  logic [NSRC-1:0] set_bits, clr_bits;
  logic            stat_rd;

  assign stat_rd  = bus_rd && (bus_addr == A_STAT);
  assign set_bits = (bus_wr && bus_addr == A_SET) ? bus_wdata[NSRC-1:0] : '0;
  assign clr_bits = (bus_wr && bus_addr == A_CLR) ? bus_wdata[NSRC-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      en_q     <= '0;
    end else begin
      status_q <= (stat_rd ? '0 : status_q) | ev_i;
      en_q     <= (en_q | set_bits) & ~clr_bits;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      case (bus_addr)
        A_STAT:  bus_rdata = {{PAD{1'b0}}, status_q};
        A_MASK:  bus_rdata = {{PAD{1'b0}}, ~en_q};
        default: bus_rdata = '0;
      endcase
    end
  end

  assign irq_o = |(status_q & en_q);
endmodule

// File: rtl/irq_gather_chk.sv
module irq_gather_chk #(
  parameter int NSRC = 15,
  parameter int DW   = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NSRC-1:0] ev_i,
  input logic            bus_wr,
  input logic            bus_rd,
  input logic [1:0]      bus_addr,
  input logic [DW-1:0]   bus_wdata,
  input logic            irq_o,
  input logic [NSRC-1:0] status_q,
  input logic [NSRC-1:0] en_q
);
  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && bus_addr == 2'd0) |=> ((status_q & $past(status_q)) == $past(status_q))); // R2
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == 2'd0 && ev_i == '0) |=> (status_q == '0)); // R3
  AST_EVENT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_i != '0) |=> ((status_q & $past(ev_i)) == $past(ev_i))); // R4
  AST_SET_APPLIES: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd1) |=> ((en_q & $past(bus_wdata[NSRC-1:0])) == $past(bus_wdata[NSRC-1:0]))); // R5
  AST_CLR_APPLIES: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd2) |=> ((en_q & $past(bus_wdata[NSRC-1:0])) == '0)); // R6
  AST_EN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && (bus_addr == 2'd1 || bus_addr == 2'd2)) |=> $stable(en_q)); // R9
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0 || status_q == '0) |-> !irq_o); // R8
endmodule

bind irq_gather irq_gather_chk #(.NSRC(NSRC), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ev_i(ev_i), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .irq_o(irq_o),
  .status_q(status_q), .en_q(en_q)
);

// File: tb/irq_gather_tb.sv
module irq_gather_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [14:0] ev = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int errors = 0, checks = 0;
  bit done = 0;
  logic [14:0] m_st = '0, m_en = '0;

  always #2 clk = ~clk;

  irq_gather u_dut (
    .clk(clk), .rst_n(rst_n), .ev_i(ev), .bus_wr(wr), .bus_rd(rd),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata), .irq_o(irq)
  );

  function automatic logic [31:0] exp_rd(input logic [1:0] a);
    case (a)
      2'd0:    return {17'd0, m_st};
      2'd3:    return {17'd0, ~m_en};
      default: return 32'd0;
    endcase
  endfunction

  function automatic logic exp_irq();
    return |(m_st & m_en);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(input logic [14:0] e, input logic w, input logic r,
                     input logic [1:0] a, input logic [31:0] d, input string tag);
    ev = e; wr = w; rd = r; addr = a; wdata = d;
    #1;
    chk("R8", {31'd0, irq}, {31'd0, exp_irq()});
    if (r) chk(tag, rdata, exp_rd(a));
    @(posedge clk); #1;
    if (r && a == 2'd0) m_st = '0;
    m_st = m_st | e;
    if (w && a == 2'd1) m_en = m_en | d[14:0];
    if (w && a == 2'd2) m_en = m_en & ~d[14:0];
    ev = '0; wr = 1'b0; rd = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    #1 chk("R1", {31'd0, irq}, 32'd0);
    cyc('0, 0, 1, 2'd0, 0, "R1");
    cyc('0, 0, 1, 2'd3, 0, "R1");
    // R5/R6 zero writes have no effect
    cyc('0, 1, 0, 2'd1, 32'h0, "R5");
    cyc('0, 0, 1, 2'd3, 0, "R5");
    // R2 masked events latch, no irq
    cyc(15'h0005, 0, 0, 2'd0, 0, "R2");
    cyc('0, 0, 1, 2'd3, 0, "R10");
    cyc('0, 0, 1, 2'd0, 0, "R2");
    cyc(15'h4001, 0, 0, 2'd0, 0, "R2");
    // R5 enable, R8 irq rises
    cyc('0, 1, 0, 2'd1, 32'h0000_4000, "R5");
    cyc('0, 0, 1, 2'd3, 0, "R7");
    chk("R8", {31'd0, irq}, 32'd1);
    // R9 writes to status and mask addresses ignored, reads of write regs zero
    cyc('0, 1, 0, 2'd0, 32'hFFFF_FFFF, "R9");
    cyc('0, 1, 0, 2'd3, 32'hFFFF_FFFF, "R9");
    cyc('0, 0, 1, 2'd1, 0, "R9");
    cyc('0, 0, 1, 2'd2, 0, "R9");
    // R6 disable drops irq; zero disable write no effect
    cyc('0, 1, 0, 2'd2, 32'h0, "R6");
    chk("R6", {31'd0, irq}, 32'd1);
    cyc('0, 1, 0, 2'd2, 32'hFFFF_4000, "R6");
    cyc('0, 0, 1, 2'd3, 0, "R6");
    // R3 read clears, R4 event during read survives
    cyc(15'h0100, 0, 1, 2'd0, 0, "R3");
    cyc('0, 0, 1, 2'd0, 0, "R4");
    cyc('0, 0, 1, 2'd0, 0, "R3");
    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [14:0] e;
      logic [31:0] d;
      int op;
      e = 15'($urandom & $urandom & $urandom);
      d = $urandom;
      op = int'($urandom % 6);
      case (op)
        0: cyc(e, 1, 0, 2'd1, d, "R5");
        1: cyc(e, 1, 0, 2'd2, d & $urandom, "R6");
        2: cyc(e, 0, 1, 2'd0, 0, "R3");
        3: cyc(e, 0, 1, 2'd3, 0, "R7");
        4: cyc(e, 1, 0, 2'($urandom), d, "R9");
        default: cyc(e, 0, 0, 2'd0, 0, "R2");
      endcase
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule